// File: doc/BRIEF.md
# FIR Tap Sequencer with Priming

This block runs a real-valued FIR filter of programmable length over two internal memories: a tap history holding past input samples and a coefficient store. Samples arrive through a four-entry input queue. Each accepted sample becomes the newest tap. When a result is due, the sequencer walks every tap together with its matching coefficient, feeds the pairs to a pipelined multiply-accumulate unit, and places the sum in a held output register. Software or a neighbouring engine loads the coefficients through a write port. While the block is disabled, it can also preset older history entries through a second write port.

Two options shape the start of a run and the output rate. With priming on, the first length-minus-one samples after enable only fill the history. With priming off, the history is taken as already preset, and the very first sample yields a result. A 4-bit decimation field keeps absorbing every sample into the history but computes only one result per group of accepted samples. A full output register or an empty input queue stalls the sequencer.

Top module: `fir_tap_seq`

## Requirements
- R1: The input queue holds at most 4 words. `in_ready` is low while 4 words wait, and a word offered while `in_ready` is low is dropped and never filtered.
- R2: Each accepted sample becomes tap 0 and every older tap ages by one. A result equals the signed sum over k from 0 to L-1 of coef[k]·tap[k], where coef[k] is the coefficient written at `coef_addr` k and tap[k] is the sample k positions older than the newest. The sum is 56 bits wide and is not saturated.
- R3: The filter length L is taken from `cfg_len` (1 to 16). Coefficients at addresses L and above have no effect on the result.
- R4: With `cfg_prime_off` = 0, the first L-1 samples accepted after `enable` rises produce no result. Sample L is the first one filtered.
- R5: With `cfg_prime_off` = 1, the first accepted sample produces a result. Taps 1 to L-1 are the values written while `enable` is low through `tap_age` = a, which sets the entry that becomes tap a once the next sample arrives.
- R6: A `cfg_decim` value v gives a ratio of v+1. After priming, the first filtered sample yields a result and then every (v+1)-th accepted sample does. Skipped samples still enter the history. A value of 15 gives one result per 16 samples.
- R7: `out_valid` stays high and `out_data` stays unchanged until a cycle with `out_ack` high. While `out_valid` is high, no queue word is consumed.
- R8: After reset, `out_valid` is 0 and `in_ready` is 1.
- R9: While `enable` is low, no queued word is consumed and no result is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the sequencer; low clears priming and decimation progress |
| cfg_len | input | 5 | Filter length L (1 to 16) |
| cfg_prime_off | input | 1 | 1 = history preset, filter from first sample |
| cfg_decim | input | 4 | Decimation ratio minus one |
| in_valid | input | 1 | Input sample offered |
| in_data | input | 24 | Signed input sample |
| in_ready | output | 1 | Queue has room |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 4 | Coefficient index |
| coef_wdata | input | 24 | Signed coefficient |
| tap_we | input | 1 | History preset strobe (honoured while disabled) |
| tap_age | input | 4 | Age of the preset entry relative to the next sample |
| tap_wdata | input | 24 | Preset sample value |
| out_valid | output | 1 | Result waiting |
| out_data | output | 56 | Signed filter result |
| out_ack | input | 1 | Result taken |

## Verification
The hardest condition to reach from the ports is a fully backed-up pipeline: a result held unread while the queue is also full. The bench reaches it by using a short filter with priming on and pushing six samples back to back without acknowledging anything. The second sample then produces a result that blocks the register, and the next four fill the queue. The bench then checks that `in_ready` is low, that the held result is stable, and that all queued samples come out in order once acknowledged. The 16-sample decimation boundary and the silent priming window are each checked by feeding one sample at a time and confirming that nothing appears within a generous wait.

// File: rtl/fir_seq_pkg.sv
package fir_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } seq_state_t;
endpackage

// File: rtl/fir_in_fifo.sv
module fir_in_fifo #(
  parameter int W     = 24,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic                         full,
  output logic                         empty,
  output logic [$clog2(DEPTH):0]       count
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (push) store[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push) wptr <= wptr + PW'(1);
      if (pop)  rptr <= rptr + PW'(1);
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = store[rptr];
  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign count = cnt;
endmodule

// File: rtl/fir_sdp_ram.sv
module fir_sdp_ram #(
  parameter int W     = 24,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [W-1:0]             rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fir_mac.sv
module fir_mac #(
  parameter int DW    = 24,
  parameter int CW    = 24,
  parameter int ACC_W = 56
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    in_vld,
  input  logic signed [DW-1:0]    a,
  input  logic signed [CW-1:0]    b,
  output logic signed [ACC_W-1:0] acc,
  output logic                    busy
);
  localparam int PW = DW + CW;

  logic signed [PW-1:0] prod;
  logic                 prod_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      prod     <= '0;
      prod_vld <= 1'b0;
      acc      <= '0;
    end else begin
      prod     <= a * b;
      prod_vld <= in_vld;
      if (clr)           acc <= '0;
      else if (prod_vld) acc <= acc + ACC_W'(prod);
    end
  end

  assign busy = prod_vld;
endmodule

// File: rtl/fir_tap_seq.sv
module fir_tap_seq #(
  parameter int DATA_W     = 24,
  parameter int COEF_W     = 24,
  parameter int ACC_W      = 56,
  parameter int MAX_TAPS   = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int DEC_W      = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        enable,
  input  logic [$clog2(MAX_TAPS):0]   cfg_len,
  input  logic                        cfg_prime_off,
  input  logic [DEC_W-1:0]            cfg_decim,
  input  logic                        in_valid,
  input  logic [DATA_W-1:0]           in_data,
  output logic                        in_ready,
  input  logic                        coef_we,
  input  logic [$clog2(MAX_TAPS)-1:0] coef_addr,
  input  logic [COEF_W-1:0]           coef_wdata,
  input  logic                        tap_we,
  input  logic [$clog2(MAX_TAPS)-1:0] tap_age,
  input  logic [DATA_W-1:0]           tap_wdata,
  output logic                        out_valid,
  output logic [ACC_W-1:0]            out_data,
  input  logic                        out_ack
);
  import fir_seq_pkg::*;

  localparam int AW    = $clog2(MAX_TAPS);
  localparam int LEN_W = AW + 1;
  localparam int FCW   = $clog2(FIFO_DEPTH) + 1;

  // input queue
  logic              fifo_full, fifo_empty, push, pop;
  logic [DATA_W-1:0] fifo_dout;
  logic [FCW-1:0]    fifo_cnt;

  // sequencer state
  seq_state_t        state;
  logic [AW-1:0]     nxt;
  logic [AW-1:0]     kidx;
  logic [LEN_W-1:0]  prime_cnt;
  logic [DEC_W-1:0]  dcnt;
  logic              out_full;
  logic [ACC_W-1:0]  out_reg;
  logic              iss, vld1, prime_done;

  // memory ports
  logic              t_we;
  logic [AW-1:0]     t_waddr, t_raddr;
  logic [DATA_W-1:0] t_wdata, t_q;
  logic [COEF_W-1:0] c_q;
  logic [ACC_W-1:0]  acc;
  logic              mac_busy;

  assign push       = in_valid & ~fifo_full;
  assign prime_done = cfg_prime_off | (prime_cnt >= (cfg_len - LEN_W'(1)));
  assign pop        = enable & (state == ST_IDLE) & ~fifo_empty & ~out_full;
  assign iss        = (state == ST_RUN);

  fir_in_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .din(in_data), .pop(pop),
    .dout(fifo_dout), .full(fifo_full), .empty(fifo_empty), .count(fifo_cnt)
  );

  // tap history: circular buffer, next free slot at nxt
  assign t_we    = pop | (tap_we & ~enable);
  assign t_waddr = pop ? nxt : (nxt - tap_age);
  assign t_wdata = pop ? fifo_dout : tap_wdata;
  assign t_raddr = nxt - AW'(1) - kidx;

  fir_sdp_ram #(.W(DATA_W), .DEPTH(MAX_TAPS)) u_taps (
    .clk(clk), .we(t_we), .waddr(t_waddr), .wdata(t_wdata),
    .raddr(t_raddr), .rdata(t_q)
  );

  fir_sdp_ram #(.W(COEF_W), .DEPTH(MAX_TAPS)) u_coefs (
    .clk(clk), .we(coef_we), .waddr(coef_addr), .wdata(coef_wdata),
    .raddr(kidx), .rdata(c_q)
  );

  fir_mac #(.DW(DATA_W), .CW(COEF_W), .ACC_W(ACC_W)) u_mac (
    .clk(clk), .rst(rst), .clr(pop), .in_vld(vld1),
    .a(t_q), .b(c_q), .acc(acc), .busy(mac_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      nxt       <= '0;
      kidx      <= '0;
      prime_cnt <= '0;
      dcnt      <= '0;
      out_full  <= 1'b0;
      out_reg   <= '0;
      vld1      <= 1'b0;
    end else begin
      vld1 <= iss;
      if (!enable) begin
        prime_cnt <= '0;
        dcnt      <= '0;
      end
      if (out_full && out_ack) out_full <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (pop) begin
            nxt  <= nxt + AW'(1);
            kidx <= '0;
            if (!prime_done) begin
              prime_cnt <= prime_cnt + LEN_W'(1);
            end else if (dcnt == '0) begin
              dcnt  <= cfg_decim;
              state <= ST_RUN;
            end else begin
              dcnt <= dcnt - DEC_W'(1);
            end
          end
        end
        ST_RUN: begin
          if (LEN_W'(kidx) == (cfg_len - LEN_W'(1))) state <= ST_DRAIN;
          else kidx <= kidx + AW'(1);
        end
        ST_DRAIN: begin
          if (!vld1 && !mac_busy) begin
            out_reg  <= acc;
            out_full <= 1'b1;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = ~fifo_full;
  assign out_valid = out_full;
  assign out_data  = out_reg;
endmodule

// File: rtl/fir_tap_seq_chk.sv
module fir_tap_seq_chk #(
  parameter int ACC_W      = 56,
  parameter int FIFO_DEPTH = 4
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        enable,
  input logic                        in_ready,
  input logic                        out_valid,
  input logic                        out_ack,
  input logic [ACC_W-1:0]            out_data,
  input logic                        pop,
  input logic                        prime_done,
  input logic [$clog2(FIFO_DEPTH):0] fifo_cnt
);
  assert_queue_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && !pop) |=> $stable(fifo_cnt));

  assert_prime_silent_R4: assert property (@(posedge clk) disable iff (rst)
    ($rose(out_valid) && enable) |-> prime_done);

  assert_out_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ack) |=> (out_valid && $stable(out_data)));

  assert_no_pop_full_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !pop);

  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> !out_valid);

  assert_disabled_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !enable |-> !pop);
endmodule

bind fir_tap_seq fir_tap_seq_chk #(.ACC_W(ACC_W), .FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .in_ready(in_ready),
  .out_valid(out_valid), .out_ack(out_ack), .out_data(out_data),
  .pop(pop), .prime_done(prime_done), .fifo_cnt(fifo_cnt)
);

// File: tb/fir_tap_seq_bench.sv
`timescale 1ns/1ps
module fir_tap_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic [4:0]  cfg_len = 5'd1;
  logic        cfg_prime_off = 1'b0;
  logic [3:0]  cfg_decim = 4'd0;
  logic        in_valid = 1'b0;
  logic [23:0] in_data = '0;
  logic        in_ready;
  logic        coef_we = 1'b0;
  logic [3:0]  coef_addr = '0;
  logic [23:0] coef_wdata = '0;
  logic        tap_we = 1'b0;
  logic [3:0]  tap_age = '0;
  logic [23:0] tap_wdata = '0;
  logic        out_valid;
  logic [55:0] out_data;
  logic        out_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic signed [23:0] cm [16];
  logic signed [23:0] mt [16];

  always #10 clk = ~clk;

  fir_tap_seq u_fir_tap_seq (
    .clk(clk), .rst(rst), .enable(enable), .cfg_len(cfg_len),
    .cfg_prime_off(cfg_prime_off), .cfg_decim(cfg_decim),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_wdata(coef_wdata),
    .tap_we(tap_we), .tap_age(tap_age), .tap_wdata(tap_wdata),
    .out_valid(out_valid), .out_data(out_data), .out_ack(out_ack)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint outv();
    return longint'($signed(out_data));
  endfunction

  function automatic longint expected(input int len);
    longint s = 0;
    for (int k = 0; k < len; k++) begin
      longint a = cm[k];
      longint b = mt[k];
      s += a * b;
    end
    return s;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; enable = 1'b0; in_valid = 1'b0; out_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic load_coef(input int k, input logic signed [23:0] v);
    coef_we = 1'b1; coef_addr = 4'(k); coef_wdata = v;
    @(negedge clk);
    coef_we = 1'b0;
    cm[k] = v;
  endtask

  task automatic preload(input int age, input logic signed [23:0] v);
    tap_we = 1'b1; tap_age = 4'(age); tap_wdata = v;
    @(negedge clk);
    tap_we = 1'b0;
    mt[age-1] = v;
  endtask

  task automatic push(input logic signed [23:0] x, output bit acc);
    acc = in_ready;
    in_valid = 1'b1; in_data = x;
    @(negedge clk);
    in_valid = 1'b0;
    if (acc) begin
      for (int k = 15; k > 0; k--) mt[k] = mt[k-1];
      mt[0] = x;
    end
  endtask

  task automatic wait_out(input int max, output bit got);
    got = 0;
    for (int i = 0; i < max; i++) begin
      if (out_valid) begin got = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic ack();
    out_ack = 1'b1;
    @(negedge clk);
    out_ack = 1'b0;
  endtask

  task automatic feed(input logic signed [23:0] x, input bit want, input int len, input string req);
    bit acc, got;
    longint e;
    push(x, acc);
    e = expected(len);
    wait_out(60, got);
    if (want) begin
      check(got, req, longint'(got), 1);
      if (got) begin
        check(outv() == e, req, outv(), e);
        ack();
      end
    end else begin
      check(!got, req, longint'(got), 0);
      if (got) ack();
    end
  endtask

  task automatic t_reset();
    do_reset();
    check(out_valid == 1'b0, "R8", longint'(out_valid), 0);
    check(in_ready == 1'b1, "R8", longint'(in_ready), 1);
  endtask

  task automatic t_queue_drop();
    bit acc, got;
    do_reset();
    cfg_len = 5'd1; cfg_prime_off = 1'b1; cfg_decim = 4'd0;
    load_coef(0, 24'sd1);
    for (int i = 0; i < 5; i++) begin
      push(24'(i * 11 + 5), acc);
      if (i == 4) check(!acc, "R1", longint'(acc), 0);
    end
    repeat (20) @(negedge clk);
    check(out_valid == 1'b0, "R9", longint'(out_valid), 0);
    check(in_ready == 1'b0, "R9", longint'(in_ready), 0);
    enable = 1'b1;
    for (int i = 0; i < 4; i++) begin
      wait_out(60, got);
      check(got, "R1", longint'(got), 1);
      check(outv() == longint'(i * 11 + 5), "R1", outv(), longint'(i * 11 + 5));
      ack();
    end
    wait_out(40, got);
    check(!got, "R1", longint'(got), 0);
  endtask

  task automatic t_maxlen();
    do_reset();
    cfg_len = 5'd16; cfg_prime_off = 1'b0; cfg_decim = 4'd0;
    for (int k = 0; k < 16; k++) load_coef(k, -24'sd8388608);
    enable = 1'b1;
    for (int i = 0; i < 15; i++) feed(-24'sd8388608, 0, 16, "R3");
    feed(-24'sd8388608, 1, 16, "R3");
    for (int k = 0; k < 16; k++) load_coef(k, 24'(k * 1000 - 7000));
    feed(24'sd8388607, 1, 16, "R3");
  endtask

  task automatic t_prime();
    do_reset();
    cfg_len = 5'd5; cfg_prime_off = 1'b0; cfg_decim = 4'd0;
    load_coef(0, 24'sd3); load_coef(1, -24'sd2); load_coef(2, 24'sd7);
    load_coef(3, 24'sd1); load_coef(4, -24'sd5);
    enable = 1'b1;
    for (int i = 0; i < 12; i++) begin
      if (i < 4) feed(24'(i * 100 - 437), 0, 5, "R4");
      else       feed(24'(i * 100 - 437), 1, 5, "R2");
    end
  endtask

  task automatic t_preload();
    do_reset();
    cfg_len = 5'd4; cfg_prime_off = 1'b1; cfg_decim = 4'd0;
    load_coef(0, 24'sd9); load_coef(1, -24'sd4); load_coef(2, 24'sd6); load_coef(3, 24'sd2);
    preload(1, 24'sd1000); preload(2, -24'sd2000); preload(3, 24'sd3000);
    enable = 1'b1;
    for (int i = 0; i < 4; i++) feed(24'(i * 37 + 1), 1, 4, "R5");
  endtask

  task automatic t_decim();
    do_reset();
    cfg_len = 5'd3; cfg_prime_off = 1'b1; cfg_decim = 4'd2;
    load_coef(0, 24'sd5); load_coef(1, 24'sd3); load_coef(2, -24'sd1);
    preload(1, 24'sd12); preload(2, -24'sd8);
    enable = 1'b1;
    for (int i = 0; i < 9; i++) feed(24'(i * 7 - 20), (i % 3) == 0, 3, "R6");
    do_reset();
    cfg_len = 5'd1; cfg_prime_off = 1'b1; cfg_decim = 4'd15;
    load_coef(0, 24'sd1);
    enable = 1'b1;
    for (int i = 0; i < 17; i++) feed(24'(i + 300), (i == 0) || (i == 16), 1, "R6");
  endtask

  task automatic t_stall();
    longint ex [6];
    bit acc, got;
    longint held;
    do_reset();
    cfg_len = 5'd2; cfg_prime_off = 1'b0; cfg_decim = 4'd0;
    load_coef(0, 24'sd4); load_coef(1, -24'sd3);
    enable = 1'b1;
    for (int i = 0; i < 6; i++) begin
      while (!in_ready) @(negedge clk);
      push(24'(i * 50 + 9), acc);
      ex[i] = expected(2);
    end
    repeat (30) @(negedge clk);
    check(out_valid == 1'b1, "R7", longint'(out_valid), 1);
    check(outv() == ex[1], "R7", outv(), ex[1]);
    check(in_ready == 1'b0, "R1", longint'(in_ready), 0);
    held = outv();
    repeat (10) @(negedge clk);
    check(outv() == held, "R7", outv(), held);
    ack();
    for (int i = 2; i < 6; i++) begin
      wait_out(60, got);
      check(got, "R7", longint'(got), 1);
      check(outv() == ex[i], "R7", outv(), ex[i]);
      ack();
    end
  endtask

  initial begin
    for (int k = 0; k < 16; k++) begin cm[k] = '0; mt[k] = '0; end
    t_reset();
    t_queue_drop();
    t_maxlen();
    t_prime();
    t_preload();
    t_decim();
    t_stall();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(64'd200000 * 20);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule